// File: doc/BRIEF.md
# DMA Request Router and Tiered Channel Arbiter

This block sits between the peripheral request lines of a DMA engine and its channels. Each request line owns a small mapping register. The register names a target channel and carries a valid flag. A line whose mapping is valid raises the request input of its channel. When several valid lines name the same channel, their requests merge into one. The routed per-channel requests are brought out so that the channel logic can see them.

Channels that are requesting and marked active compete for the shared memory port. The arbiter sorts channels into four fixed tiers that repeat every sixteen channels, and within a tier it rotates fairly. It issues a one-hot grant and holds it until the granted channel reports the end of its burst. A read-only summary word shows one bit per channel with a pending interrupt.

The arbiter is a two-state machine. In state ARB_IDLE no grant is held, and the transition "pick" moves it to ARB_HOLD when any channel is competing. In that transition the grant is loaded and the rotation pointer of the winning tier is updated. In state ARB_HOLD the grant is held. The transition "release" returns the machine to ARB_IDLE on the cycle `burst_done` is seen, and it clears the grant.

Top module: `dma_req_router`

## Requirements
- R1: A write to the mapping register of a line stores the channel number from data bits 4:0 and the valid flag from bit 7. A read returns those fields in the same positions, and the other bits read as zero. For lines 0 to 63 the register is at address 0x100 + 4·n.
- R2: For lines 64 and above, the mapping register is at address 0x1100 + 4·(n − 64).
- R3: While its mapping is valid, a line asserts the routed request of the channel it names, in the same cycle. A line whose mapping is not valid affects no channel. This includes a line after its register has been written with zero.
- R4: When two or more valid mappings name the same channel, that channel's routed request is the OR of those lines.
- R5: A read at address 0x0F0 returns the summary word. Bit c of the summary word equals the interrupt flag of channel c, and bits at or above the channel count are zero.
- R6: A channel competes when its routed request and its active flag are both high. A channel is in tier ((c mod 16) div 4), and tier 0 has the highest priority. A channel of a lower tier is granted only when no channel of a higher tier competes.
- R7: Within a tier, the search for the next grant starts at the channel after the one last granted in that tier, in increasing channel order with wrap-around.
- R8: The grant is one-hot. It appears on the clock edge after arbitration and is held unchanged until `burst_done` is sampled high. On that edge the grant clears for one cycle, and arbitration runs again on the following edge.
- R9: After reset no mapping is valid and no grant is held. In every tier the first search starts at channel 0.
- R10: A read of any address that holds neither a mapping register nor the summary word returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for the register write and the read |
| reg_wdata | input | 8 | Write data for a mapping register |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| line_req | input | NUM_LINES | Peripheral request lines |
| ch_active | input | NUM_CH | Per-channel flag: channel may take the port |
| irq_flags | input | NUM_CH | Per-channel pending interrupt flags |
| burst_done | input | 1 | The granted channel has finished its burst |
| ch_req | output | NUM_CH | Routed per-channel requests |
| grant | output | NUM_CH | One-hot port grant |
| irq_summary | output | 32 | Interrupt summary word |

## Verification
The bench uses 32 channels and 72 request lines. With 32 channels all four tiers are full, each with two groups of four, so rotation across the sixteen-channel repeat can be exercised. With 72 lines, the second register bank starting at 0x1100 can be reached. The bench also drives a line whose mapping shares a channel with another line, writes zero to clear a mapping, and gates a request with the active flag. It raises a higher-tier request while a lower-tier grant is held and checks the grant does not change.

// File: rtl/dma_rt_pkg.sv
package dma_rt_pkg;

    localparam int LO_BANK_BASE = 32'h0100;
    localparam int HI_BANK_BASE = 32'h1100;
    localparam int LO_BANK_LINES = 64;
    localparam int SUMMARY_ADDR = 32'h00F0;
    localparam int CHAN_FIELD_W = 5;
    localparam int VALID_POS = 7;
    localparam int TIER_COUNT = 4;
    localparam int TIER_SPAN = 4;
    localparam int TIER_REPEAT = TIER_COUNT * TIER_SPAN;
    localparam int TIER_W = $clog2(TIER_COUNT);
    localparam int SUMMARY_W = 32;

    typedef struct packed {
        logic                    valid;
        logic [CHAN_FIELD_W-1:0] chan;
    } map_entry_t;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_t;

    function automatic int tier_of(input int c);
        return (c % TIER_REPEAT) / TIER_SPAN;
    endfunction

    function automatic int map_addr_of(input int n);
        if (n < LO_BANK_LINES)
            return LO_BANK_BASE + 4 * n;
        else
            return HI_BANK_BASE + 4 * (n - LO_BANK_LINES);
    endfunction

endpackage

// File: rtl/line_map.sv
module line_map
    import dma_rt_pkg::*;
#(
    parameter int NUM_LINES = 72,
    parameter int NUM_CH    = 32,
    parameter int ADDR_W    = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic [NUM_LINES-1:0] line_req,
    output logic [NUM_CH-1:0]    ch_req,
    output logic [7:0]           rd_byte
);

    map_entry_t map_q [NUM_LINES];

    logic unused_wbits;
    assign unused_wbits = ^reg_wdata[6:5];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam logic [ADDR_W-1:0] LINE_ADDR = ADDR_W'(map_addr_of(l));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map_q[l] <= '0;
            end else if (reg_we && reg_addr == LINE_ADDR) begin
                map_q[l].valid <= reg_wdata[VALID_POS];
                map_q[l].chan  <= reg_wdata[CHAN_FIELD_W-1:0];
            end
        end
    end

    always_comb begin
        ch_req = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (line_req[l] && map_q[l].valid && int'(map_q[l].chan) == c)
                    ch_req[c] = 1'b1;
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (reg_addr == ADDR_W'(map_addr_of(l)))
                rd_byte = {map_q[l].valid, 2'b00, map_q[l].chan};
        end
    end

endmodule

// File: rtl/tier_arbiter.sv
module tier_arbiter
    import dma_rt_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_active,
    input  logic              burst_done,
    output logic [NUM_CH-1:0] grant
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    arb_state_t             state_q, state_n;
    logic [IDX_W-1:0]       ptr_q [TIER_COUNT];
    logic [NUM_CH-1:0]      compete;
    logic                   pick_found;
    logic [IDX_W-1:0]       pick_idx;
    logic [TIER_W-1:0]      pick_tier;
    logic [NUM_CH-1:0]      pick_oh;

    assign compete = ch_req & ch_active;

    always_comb begin
        pick_found = 1'b0;
        pick_idx   = '0;
        pick_tier  = '0;
        for (int t = 0; t < TIER_COUNT; t++) begin
            for (int off = 1; off <= NUM_CH; off++) begin
                int c;
                c = (int'(ptr_q[t]) + off) % NUM_CH;
                if (!pick_found && compete[c] && tier_of(c) == t) begin
                    pick_found = 1'b1;
                    pick_idx   = IDX_W'(c);
                    pick_tier  = TIER_W'(t);
                end
            end
        end
    end

    always_comb begin
        pick_oh = '0;
        pick_oh[pick_idx] = 1'b1;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ARB_IDLE: if (pick_found) state_n = ARB_HOLD;
            ARB_HOLD: if (burst_done) state_n = ARB_IDLE;
            default:  state_n = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant <= '0;
            for (int t = 0; t < TIER_COUNT; t++)
                ptr_q[t] <= IDX_W'(NUM_CH - 1);
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (pick_found) begin
                        grant <= pick_oh;
                        ptr_q[pick_tier] <= pick_idx;
                    end
                end
                ARB_HOLD: begin
                    if (burst_done) grant <= '0;
                end
                default: grant <= '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import dma_rt_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic [NUM_CH-1:0]    irq_flags,
    output logic [SUMMARY_W-1:0] summary
);

    if (NUM_CH < SUMMARY_W) begin : g_pad
        assign summary = {{(SUMMARY_W - NUM_CH){1'b0}}, irq_flags};
    end else begin : g_full
        assign summary = irq_flags[SUMMARY_W-1:0];
    end

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
    import dma_rt_pkg::*;
#(
    parameter int NUM_LINES = 72,
    parameter int NUM_CH    = 32,
    parameter int ADDR_W    = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] line_req,
    input  logic [NUM_CH-1:0]    ch_active,
    input  logic [NUM_CH-1:0]    irq_flags,
    input  logic                 burst_done,
    output logic [NUM_CH-1:0]    ch_req,
    output logic [NUM_CH-1:0]    grant,
    output logic [31:0]          irq_summary
);

    logic [7:0] map_rd;

    line_map #(
        .NUM_LINES (NUM_LINES),
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .line_req  (line_req),
        .ch_req    (ch_req),
        .rd_byte   (map_rd)
    );

    tier_arbiter #(
        .NUM_CH (NUM_CH)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_req     (ch_req),
        .ch_active  (ch_active),
        .burst_done (burst_done),
        .grant      (grant)
    );

    irq_summary #(
        .NUM_CH (NUM_CH)
    ) u_sum (
        .irq_flags (irq_flags),
        .summary   (irq_summary)
    );

    always_comb begin
        if (reg_addr == ADDR_W'(SUMMARY_ADDR))
            reg_rdata = irq_summary;
        else
            reg_rdata = {24'b0, map_rd};
    end

endmodule

// File: rtl/dma_req_router_checker.sv
module dma_req_router_checker #(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [NUM_CH-1:0] irq_flags,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_active,
    input logic              burst_done,
    input logic [NUM_CH-1:0] grant
);

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !burst_done) |=> $stable(grant));

    assert_grant_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && burst_done) |=> grant == '0);

    assert_idle_picks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && (ch_req & ch_active) != '0) |=> grant != '0);

    assert_grant_from_compete_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> (grant == '0 || (grant & $past(ch_req & ch_active)) != '0));

    assert_summary_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(32'h0F0)) |-> reg_rdata == 32'(irq_flags));

endmodule

bind dma_req_router dma_req_router_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .irq_flags  (irq_flags),
    .ch_req     (ch_req),
    .ch_active  (ch_active),
    .burst_done (burst_done),
    .grant      (grant)
);

// File: tb/test_dma_req_router.sv
module test_dma_req_router;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 72;
    localparam int NC = 32;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] line_req = '0;
    logic [NC-1:0] ch_active = '0;
    logic [NC-1:0] irq_flags = '0;
    logic          burst_done = 1'b0;
    logic [NC-1:0] ch_req;
    logic [NC-1:0] grant;
    logic [31:0]   irq_summary;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_req_router #(.NUM_LINES(NL), .NUM_CH(NC), .ADDR_W(AW)) i_dma_req_router (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_req(line_req),
        .ch_active(ch_active), .irq_flags(irq_flags), .burst_done(burst_done),
        .ch_req(ch_req), .grant(grant), .irq_summary(irq_summary)
    );

    // {line_req[31:0], ch_active, expected grant index}; lines 0..31 map to channel = line
    localparam logic [68:0] ARB_VEC [12] = '{
        {32'h0002_0021, 32'hFFFF_FFFF, 5'd0},   // R9 R6: tier 0 first from 0
        {32'h0002_0021, 32'hFFFF_FFFF, 5'd17},  // R7 rotate
        {32'h0002_0021, 32'hFFFF_FFFF, 5'd0},   // R7 wrap
        {32'h0020_0220, 32'hFFFF_FFFF, 5'd5},   // R6 tier 1 over tier 2
        {32'h0020_0220, 32'hFFFF_FFFF, 5'd21},  // R7
        {32'h1000_1200, 32'hFFFF_FFFF, 5'd9},   // R6 tier 2 over tier 3
        {32'h9000_1000, 32'hFFFF_FFFF, 5'd12},  // R6 tier 3
        {32'h9000_1000, 32'hFFFF_FFFF, 5'd28},  // R7
        {32'h9000_1000, 32'hFFFF_FFFF, 5'd31},  // R7
        {32'h0000_1001, 32'hFFFF_FFFE, 5'd12},  // R6 inactive channel 0 does not compete
        {32'h0001_0008, 32'hFFFF_FFFF, 5'd3},   // R7 search after 0
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd16}   // R6 R7 all requesting
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [7:0] data);
        reg_we = 1'b1;
        reg_addr = AW'(addr);
        reg_wdata = data;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input int addr, input logic [31:0] exp);
        reg_addr = AW'(addr);
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        line_req = '1;
        repeat (3) tick();
        check("R9 grant at reset", grant, 32'h0);
        check("R9 no valid map", ch_req, 32'h0);
        rst_n = 1'b1;
        tick();
        rd_check("R9 map line 0", 32'h100, 32'h0);
        check("R9 grant after reset", grant, 32'h0);
        line_req = '0;

        for (int i = 0; i < 32; i++) wr(32'h100 + 4 * i, 8'h80 | 8'(i));
        rd_check("R1 line 5 read", 32'h114, 32'h85);

        wr(32'h1A0, 8'hFF);
        rd_check("R1 reserved bits read zero", 32'h1A0, 32'h9F);
        line_req[40] = 1'b1;
        #1 check("R3 line 40 to channel 31", ch_req, 32'h8000_0000);
        wr(32'h1A0, 8'h00);
        #1 check("R3 cleared mapping drives nothing", ch_req, 32'h0);
        rd_check("R3 cleared read", 32'h1A0, 32'h0);
        line_req = '0;

        wr(32'h1108, 8'h87);
        rd_check("R2 high bank line 66", 32'h1108, 32'h87);
        rd_check("R2 low bank alias untouched", 32'h208, 32'h0);
        line_req[66] = 1'b1;
        #1 check("R2 line 66 to channel 7", ch_req, 32'h80);
        line_req[7] = 1'b1;
        #1 check("R4 two lines one channel", ch_req, 32'h80);
        line_req[66] = 1'b0;
        #1 check("R4 line 7 alone", ch_req, 32'h80);
        line_req = '0;
        wr(32'h1108, 8'h00);
        line_req[66] = 1'b1;
        #1 check("R3 zero write unmaps line 66", ch_req, 32'h0);
        line_req = '0;

        irq_flags = 32'hA5A5_0003;
        rd_check("R5 summary read", 32'h0F0, 32'hA5A5_0003);
        check("R5 summary port", irq_summary, 32'hA5A5_0003);
        rd_check("R10 unmapped low", 32'h000, 32'h0);
        rd_check("R10 unmapped high", 32'h1000, 32'h0);

        for (int i = 0; i < 12; i++) begin
            line_req = '0;
            line_req[31:0] = ARB_VEC[i][68:37];
            ch_active = ARB_VEC[i][36:5];
            tick();
            check($sformatf("R6 R7 vector %0d grant", i), grant, 32'h1 << ARB_VEC[i][4:0]);
            burst_done = 1'b1;
            tick();
            check($sformatf("R8 vector %0d release", i), grant, 32'h0);
            burst_done = 1'b0;
        end

        line_req = '0;
        ch_active = '1;
        tick();
        line_req[13] = 1'b1;
        tick();
        check("R6 lone tier 3", grant, 32'h2000);
        line_req[1] = 1'b1;
        repeat (3) tick();
        check("R8 grant held without burst_done", grant, 32'h2000);
        burst_done = 1'b1;
        tick();
        check("R8 grant drops on burst_done", grant, 32'h0);
        burst_done = 1'b0;
        tick();
        check("R6 tier 0 wins after release", grant, 32'h2);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule